// File: doc/BRIEF.md
# UART Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial characters on a single line. A free-running oversample tick, supplied from outside, paces the receiver at a fixed number of ticks per bit. A falling edge on the idle line starts a character. The start bit is confirmed half a bit later. Each following bit is sampled at its centre, least significant bit first. The receiver takes 8 data bits, or 9 in nine-bit mode, and then one stop bit.

Finished characters go into a two-entry FIFO. Each entry holds the data, the ninth bit and a framing-error bit. The entry at the head of the FIFO drives the outputs until a read strobe removes it. If a character finishes while both entries are full, the receiver sets a sticky overrun flag and stops receiving. Dropping receive enable for at least one clock clears the flag and starts reception again.

In nine-bit mode an address-filter option discards every character whose ninth bit is 0. A break is a character in which every data bit and the stop bit are 0. When wake-on-break is enabled, a break raises a one-cycle wake pulse.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset, `avail`, `overrun` and `wake_pulse` are 0.
- R2: In 8-bit mode (`nine_bit`=0), a frame is one 0 start bit, 8 data bits LSB first and a stop bit. It appears on `dout`, with `dout_b8`=0 and, when the stop bit is 1, `dout_ferr`=0.
- R3: In 9-bit mode (`nine_bit`=1), the ninth received bit follows the 8 data bits and is presented on `dout_b8`.
- R4: A character whose stop bit samples as 0 is stored with `dout_ferr`=1. The framing-error bit belongs to each entry, and the outputs show the head entry's bit.
- R5: Up to two characters are held in arrival order. `avail` is 1 while at least one is held. A one-cycle `rd_strobe` removes the head entry.
- R6: If a character completes while two are held and no read happens in that cycle, `overrun` is set and that character is discarded. The two held entries are kept unchanged.
- R7: While `overrun` is 1, no further character is stored. `overrun` stays set until `rx_en` is 0 at a clock edge, which clears it.
- R8: With `nine_bit`=1 and `addr_det`=1, a character whose ninth bit is 0 is not stored, and a character whose ninth bit is 1 is stored.
- R9: A break (all data bits, the ninth bit if present, and the stop bit all 0) produces exactly one cycle of `wake_pulse` when `wake_en`=1, and none when `wake_en`=0.
- R10: A low pulse on `rx_in` that is shorter than half a bit period is rejected as a false start, and no character is produced.
- R11: While `rx_en`=0, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversample tick, OVS ticks per bit |
| rx_en | input | 1 | Receive enable; low clears overrun |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| addr_det | input | 1 | Drop characters with ninth bit 0 (9-bit mode) |
| wake_en | input | 1 | Enable wake pulse on break |
| rd_strobe | input | 1 | Pop the FIFO head |
| dout | output | DW | Head entry data |
| dout_b8 | output | 1 | Head entry ninth bit |
| dout_ferr | output | 1 | Head entry framing error |
| overrun | output | 1 | Sticky overrun flag |
| avail | output | 1 | FIFO holds at least one character |
| wake_pulse | output | 1 | One-cycle pulse on break |

## Verification
The bench sweeps data values in both character lengths and reads characters back in pairs. A bit-order or FIFO-order mistake therefore shows up as swapped or mirrored data.

It fills the FIFO, sends a third and a fourth character, and checks the following:
- the held entries survive;
- the fourth character is blocked;
- only a low `rx_en` frees the receiver.

A design that overwrote on overrun, or that cleared the flag on a read, would return the wrong data or keep receiving.

The bench also checks the remaining corner cases:
- A good frame is followed by a bad-stop frame, to catch a framing bit kept only once per FIFO instead of per entry.
- Address-filter frames are sent with the ninth bit both clear and set.
- Breaks are sent with wake enabled and disabled.
- A short glitch is sent, to catch a receiver that starts without a mid-bit check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned RX_OVS = 16;
  localparam int unsigned RX_DW  = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = RX_OVS,
  parameter int unsigned DW  = RX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          nine_bit,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          b8,
  output logic          ferr,
  output logic          brk
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BW = $clog2(DW + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

  rx_state_e     st;
  logic [1:0]    sy;
  logic          rxs;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW:0]   sh;
  logic          stop_q;
  logic [BW-1:0] last_bit;

  // Data sits in the upper DW bits after DW shifts, or all DW+1 bits after DW+1 shifts.
  function automatic logic [DW-1:0] pick_data(input logic [DW:0] s, input logic nine);
    return nine ? s[DW-1:0] : s[DW:1];
  endfunction

  function automatic logic is_break(input logic [DW-1:0] d, input logic n, input logic stp);
    return (d == '0) && !n && !stp;
  endfunction

  assign rxs      = sy[1];
  assign last_bit = nine_bit ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy     <= 2'b11;
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      stop_q <= 1'b1;
      done   <= 1'b0;
    end else begin
      sy   <= {sy[0], rx_in};
      done <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else if (os_tick) begin
        case (st)
          S_IDLE: if (!rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == HALF_M1) begin
            cnt <= '0;
            if (!rxs) begin
              st   <= S_DATA;
              bitn <= '0;
              sh   <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_DATA: if (cnt == FULL_M1) begin
            cnt <= '0;
            sh  <= {rxs, sh[DW:1]};
            if (bitn == last_bit) st <= S_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_STOP: if (cnt == FULL_M1) begin
            cnt    <= '0;
            done   <= 1'b1;
            stop_q <= rxs;
            st     <= rxs ? S_IDLE : S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_HOLD: if (rxs) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign data = pick_data(sh, nine_bit);
  assign b8   = nine_bit & sh[DW];
  assign ferr = ~stop_q;
  assign brk  = is_break(data, b8, stop_q);
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2 #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (fill != '0);
  assign do_push = push && ((fill != FW'(DEPTH)) || do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  assign head = mem[rp];
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS   = RX_OVS,
  parameter int unsigned DW    = RX_DW,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          rx_en,
  input  logic          nine_bit,
  input  logic          addr_det,
  input  logic          wake_en,
  input  logic          rd_strobe,
  output logic [DW-1:0] dout,
  output logic          dout_b8,
  output logic          dout_ferr,
  output logic          overrun,
  output logic          avail,
  output logic          wake_pulse
);
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DW + 2;

  logic          char_done, char_b8, char_ferr, char_brk;
  logic [DW-1:0] char_data;
  logic          accept_w, push_w, pop_w, full_w;
  logic [FW-1:0] fill_w;
  logic [EW-1:0] head_w;

  uart_rx_sampler #(.OVS(OVS), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .en(rx_en & ~overrun), .rx_in(rx_in),
    .os_tick(os_tick), .nine_bit(nine_bit), .done(char_done),
    .data(char_data), .b8(char_b8), .ferr(char_ferr), .brk(char_brk)
  );

  assign accept_w = char_done && !(nine_bit && addr_det && !char_b8);
  assign pop_w    = rd_strobe && avail;
  assign full_w   = (fill_w == FW'(DEPTH)) && !pop_w;
  assign push_w   = accept_w && !full_w;

  rx_fifo2 #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .din({char_ferr, char_b8, char_data}), .head(head_w), .fill(fill_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overrun <= 1'b0;
    else if (!rx_en)            overrun <= 1'b0;
    else if (accept_w && full_w) overrun <= 1'b1;
  end

  assign avail      = (fill_w != '0);
  assign dout       = head_w[DW-1:0];
  assign dout_b8    = head_w[DW];
  assign dout_ferr  = head_w[DW+1];
  assign wake_pulse = char_done && char_brk && wake_en;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned FW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          nine_bit,
  input logic          addr_det,
  input logic          wake_en,
  input logic          overrun,
  input logic          avail,
  input logic          wake_pulse,
  input logic          char_done,
  input logic          char_b8,
  input logic          push,
  input logic [FW-1:0] fill
);
  p_push_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> avail);
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);
  p_ovr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !push);
  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);
  p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && nine_bit && addr_det) |-> char_b8);
  p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (wake_en && char_done));
  p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

bind uart_rx_addr uart_rx_checker #(.DEPTH(DEPTH), .FW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
  .addr_det(addr_det), .wake_en(wake_en), .overrun(overrun), .avail(avail),
  .wake_pulse(wake_pulse), .char_done(char_done), .char_b8(char_b8),
  .push(push_w), .fill(fill_w)
);

// File: tb/tb_uart_rx_addr.sv
module tb_uart_rx_addr;
  localparam int OVS  = 16;
  localparam int BITC = 2 * OVS;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, os_tick = 1'b0;
  logic rx_en = 1'b0, nine_bit = 1'b0, addr_det = 1'b0, wake_en = 1'b0, rd_strobe = 1'b0;
  logic [7:0] dout;
  logic dout_b8, dout_ferr, overrun, avail, wake_pulse;
  int checks = 0, fails = 0, wakes = 0;

  uart_rx_addr dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick), .rx_en(rx_en),
    .nine_bit(nine_bit), .addr_det(addr_det), .wake_en(wake_en), .rd_strobe(rd_strobe),
    .dout(dout), .dout_b8(dout_b8), .dout_ferr(dout_ferr), .overrun(overrun),
    .avail(avail), .wake_pulse(wake_pulse)
  );

  always #10 clk = ~clk;
  initial forever begin @(negedge clk); os_tick = ~os_tick; end
  initial forever begin @(negedge clk); if (wake_pulse) wakes++; end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog got=hung exp=done");
    report();
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic hold(input logic v);
    rx_in = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input logic nine, input logic stp);
    @(negedge clk);
    hold(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) hold(v[i]);
    hold(stp);
    hold(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [7:0] d, input logic b, input logic f);
    @(negedge clk);
    chk({tag, " avail"}, avail, 1'b1);
    chk({tag, " data"}, dout, d);
    chk({tag, " b8"}, dout_b8, b);
    chk({tag, " ferr"}, dout_ferr, f);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 avail", avail, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 wake", wake_pulse, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2: single 8-bit frames over a value sweep
    for (int i = 0; i < 16; i++) begin
      send(9'(i * 17 + 3), 1'b0, 1'b1);
      rd("R2", 8'(i * 17 + 3), 1'b0, 1'b0);
    end
    // R5: pairs, order preserved
    for (int i = 0; i < 6; i++) begin
      send(9'(i * 37 + 5), 1'b0, 1'b1);
      send(9'(~(i * 37 + 5) & 8'hff), 1'b0, 1'b1);
      rd("R5 first", 8'(i * 37 + 5), 1'b0, 1'b0);
      rd("R5 second", 8'(~(i * 37 + 5)), 1'b0, 1'b0);
      @(negedge clk);
      chk("R5 empty", avail, 0);
    end
    // R3: 9-bit frames
    nine_bit = 1'b1;
    for (int i = 0; i < 8; i++) begin
      send({i[0], 8'(i * 29 + 1)}, 1'b1, 1'b1);
      rd("R3", 8'(i * 29 + 1), i[0], 1'b0);
    end
    nine_bit = 1'b0;
    // R4: per-entry framing error
    send(9'h0A5, 1'b0, 1'b1);
    send(9'h05A, 1'b0, 1'b0);
    rd("R4 good", 8'hA5, 1'b0, 1'b0);
    rd("R4 bad", 8'h5A, 1'b0, 1'b1);
    // R6/R7: overrun
    send(9'h011, 1'b0, 1'b1);
    send(9'h022, 1'b0, 1'b1);
    send(9'h033, 1'b0, 1'b1);
    chk("R6 overrun set", overrun, 1);
    rd("R6 keep first", 8'h11, 1'b0, 1'b0);
    send(9'h044, 1'b0, 1'b1);
    chk("R7 sticky", overrun, 1);
    rd("R6 keep second", 8'h22, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 blocked", avail, 0);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    chk("R7 cleared", overrun, 0);
    send(9'h055, 1'b0, 1'b1);
    rd("R7 resumed", 8'h55, 1'b0, 1'b0);
    // R8: address filter
    nine_bit = 1'b1;
    addr_det = 1'b1;
    send(9'h0C3, 1'b1, 1'b1);
    chk("R8 drop b8=0", avail, 0);
    send(9'h13C, 1'b1, 1'b1);
    rd("R8 keep b8=1", 8'h3C, 1'b1, 1'b0);
    nine_bit = 1'b0;
    send(9'h077, 1'b0, 1'b1);
    rd("R8 ignored in 8-bit", 8'h77, 1'b0, 1'b0);
    addr_det = 1'b0;
    // R9: break and wake
    wake_en = 1'b1;
    send(9'h000, 1'b0, 1'b0);
    chk("R9 wake once", wakes, 1);
    rd("R9 break stored", 8'h00, 1'b0, 1'b1);
    wake_en = 1'b0;
    send(9'h000, 1'b0, 1'b0);
    chk("R9 no wake", wakes, 1);
    rd("R9 break2", 8'h00, 1'b0, 1'b1);
    // R10: glitch rejection
    @(negedge clk);
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk("R10 glitch", avail, 0);
    // R11: disabled receiver
    rx_en = 1'b0;
    send(9'h099, 1'b0, 1'b1);
    chk("R11 disabled", avail, 0);
    report();
  end
endmodule